// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block keeps one presence bit for every CPU. The bit's position is the CPU's interrupt-controller ID. Firmware reads the bits one byte at a time over a small I/O bus. When a hot-add request arrives, the block sets the matching bit and raises a general-purpose event status bit. That status bit drives the system control interrupt (SCI) level through a per-bit enable. Hot-remove does not exist here: an event can set a bit but never clear it.

The bitmap cannot be written. Writes to its first 32-bit word have one special use, which is to detect a request to leave the legacy interface. The request is complete when zero has been written to all four bytes of that word. The block then sets a sticky mode flag. From that point the bitmap reads back as zero, and the flag clears only on reset.

Top module: `cpu_presence_map`

## Requirements
- R1: CPU n is stored at byte offset n/8, bit n%8 of the read data.
- R2: A hot-add request for CPU n sets bit n. A read issued in any later cycle returns the bit set.
- R3: Bus writes never change a presence bit.
- R4: Bit 0 of byte offset 0 always reads 1, because it stands for the boot CPU, including right after reset.
- R5: Read data is registered. It updates on the clock edge that takes a read strobe and holds its value in every other cycle, writes included.
- R6: A hot-add request sets event status bit 2 (of an 8-bit status). The SCI output is the OR over all bits of status AND the 8-bit enable input.
- R7: A clear strobe clears event status bit 2 when its data has bit 2 set. A hot-add request in the same cycle wins over the clear. Other clear data bits have no effect on bit 2.
- R8: The mode flag rises on the clock edge of the write that completes the set of zero writes to offsets 0, 1, 2 and 3 (in any order). Zero writes at offsets 4 and above do not count.
- R9: A nonzero write to any of offsets 0 to 3 discards the zero writes collected so far.
- R10: Once the mode flag is set it stays set until reset. While it is set, every read returns 0x00, while hot-add requests still update the bits and the event status.
- R11: After reset the presence bits other than bit 0 are clear, the event status is clear, the mode flag is low and the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Bus access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte offset in the bitmap window |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| hp_add_vld | input | 1 | Hot-add request strobe |
| hp_add_id | input | ID_W | Interrupt-controller ID of the added CPU |
| gpe_clr_vld | input | 1 | Event status clear strobe |
| gpe_clr_bits | input | 8 | Write-one-to-clear mask for the event status |
| gpe_en | input | 8 | Event enable mask |
| sci | output | 1 | SCI level |
| modern_mode | output | 1 | Sticky flag: legacy interface left |

## Verification
The assertions check, on every cycle, the properties that a cycle-to-cycle relation can express:
- the boot CPU bit on every read of offset 0;
- read data holding when no read is issued;
- zero reads once the mode flag is set;
- the mode flag never falling;
- the SCI staying low when all enables are low;
- a hot-add making the SCI follow its enable.

Some behaviours need whole scenarios run by the bench:
- the mapping from CPU ID to byte and bit;
- bits surviving stray writes;
- the zero-write collection being reset by a nonzero write, and its insensitivity to order and to offsets past the first word;
- a hot-add beating a same-cycle clear.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int GPE_W      = 8;
  localparam int GPE_HP_BIT = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } io_op_e;

  function automatic io_op_e decode_op(input logic sel, input logic wr);
    if (!sel)   return OP_IDLE;
    else if (wr) return OP_WR;
    else        return OP_RD;
  endfunction
endpackage

// File: rtl/cpm_bitmap.sv
module cpm_bitmap #(
  parameter int NUM_CPUS = 256,
  parameter int ADDR_W   = $clog2(NUM_CPUS / 8),
  parameter int ID_W     = $clog2(NUM_CPUS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [ID_W-1:0]   set_id,
  input  logic              rd_en,
  input  logic              rd_block,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import cpm_pkg::*;
  localparam int ROWS = NUM_CPUS / BYTE_W;

  logic [NUM_CPUS-1:0] map_q, map_d, set_mask;
  logic [BYTE_W-1:0]   rows [ROWS];
  logic [BYTE_W-1:0]   rd_q, rd_d;

  // one-hot set mask, only bits ever added
  always_comb begin
    set_mask = '0;
    if (set_vld) set_mask = NUM_CPUS'(1) << set_id;
  end

  // presence bits only accumulate; bit 0 enters at reset and never leaves
  always_comb map_d = map_q | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= NUM_CPUS'(1);
    else        map_q <= map_d;
  end

  genvar g;
  generate
    for (g = 0; g < ROWS; g++) begin : g_row
      assign rows[g] = map_q[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = rd_block ? '0 : rows[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/cpm_mode_ctl.sv
module cpm_mode_ctl #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              modern
);
  import cpm_pkg::*;
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [WORD_BYTES-1:0] zmask_q, zmask_d, zmask_nx;
  logic                  modern_q, modern_d;
  logic                  in_word;

  assign in_word = wr_addr < ADDR_W'(WORD_BYTES);

  always_comb begin
    zmask_nx = zmask_q;
    if (wr_en && in_word && !modern_q) begin
      if (wr_data == 8'h00) zmask_nx = zmask_q | (WORD_BYTES'(1) << wr_addr[LANE_W-1:0]);
      else                  zmask_nx = '0;
    end
    modern_d = modern_q;
    zmask_d  = zmask_nx;
    if (&zmask_nx) begin
      modern_d = 1'b1;
      zmask_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zmask_q  <= '0;
      modern_q <= 1'b0;
    end else if (wr_en) begin
      zmask_q  <= zmask_d;
      modern_q <= modern_d;
    end
  end

  assign modern = modern_q;
endmodule

// File: rtl/cpm_gpe.sv
module cpm_gpe #(
  parameter int GPE_W   = 8,
  parameter int HP_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hp_evt,
  input  logic             clr_vld,
  input  logic [GPE_W-1:0] clr_bits,
  input  logic [GPE_W-1:0] en,
  output logic             sci
);
  logic [GPE_W-1:0] sts_q, sts_d, clr_mask, set_mask;

  always_comb begin
    clr_mask = clr_vld ? clr_bits : '0;
    set_mask = hp_evt ? (GPE_W'(1) << HP_BIT) : '0;
    sts_d    = (sts_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sts_q <= '0;
    else if (clr_vld || hp_evt) sts_q <= sts_d;
  end

  assign sci = |(sts_q & en);
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
  parameter int NUM_CPUS = 256,
  parameter int ADDR_W   = $clog2(NUM_CPUS / 8),
  parameter int ID_W     = $clog2(NUM_CPUS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              hp_add_vld,
  input  logic [ID_W-1:0]   hp_add_id,
  input  logic              gpe_clr_vld,
  input  logic [7:0]        gpe_clr_bits,
  input  logic [7:0]        gpe_en,
  output logic              sci,
  output logic              modern_mode
);
  import cpm_pkg::*;

  io_op_e op;
  logic   rd_en, wr_en;

  assign op    = decode_op(io_sel, io_wr);
  assign rd_en = (op == OP_RD);
  assign wr_en = (op == OP_WR);

  cpm_bitmap #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_vld(hp_add_vld), .set_id(hp_add_id),
    .rd_en(rd_en), .rd_block(modern_mode), .rd_addr(io_addr),
    .rd_data(io_rdata)
  );

  cpm_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(io_addr), .wr_data(io_wdata),
    .modern(modern_mode)
  );

  cpm_gpe #(.GPE_W(GPE_W), .HP_BIT(GPE_HP_BIT)) u_gpe (
    .clk(clk), .rst_n(rst_n),
    .hp_evt(hp_add_vld), .clr_vld(gpe_clr_vld), .clr_bits(gpe_clr_bits),
    .en(gpe_en), .sci(sci)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_sel,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_rdata,
  input logic              hp_add_vld,
  input logic [7:0]        gpe_en,
  input logic              sci,
  input logic              modern_mode
);
  // R4
  boot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !io_wr && io_addr == '0 && !modern_mode) |=> io_rdata[0]);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && !io_wr) |=> $stable(io_rdata));

  // R10
  modern_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modern_mode |=> modern_mode);

  // R10
  modern_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !io_wr && modern_mode) |=> io_rdata == 8'h00);

  // R6
  sci_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpe_en == 8'h00) |-> !sci);

  // R6
  hotadd_sci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_add_vld && gpe_en[2]) |=> (sci || !gpe_en[2]));
endmodule

bind cpu_presence_map cpm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
  .io_rdata(io_rdata), .hp_add_vld(hp_add_vld), .gpe_en(gpe_en),
  .sci(sci), .modern_mode(modern_mode)
);

// File: tb/tb_cpu_presence_map.sv
module tb_cpu_presence_map;
  localparam int N  = 256;
  localparam int AW = 5;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          io_sel, io_wr;
  logic [AW-1:0] io_addr;
  logic [7:0]    io_wdata, io_rdata;
  logic          hp_add_vld;
  logic [IW-1:0] hp_add_id;
  logic          gpe_clr_vld;
  logic [7:0]    gpe_clr_bits, gpe_en;
  logic          sci, modern_mode;

  always #4 clk = ~clk;

  cpu_presence_map #(.NUM_CPUS(N)) dut (.*);

  logic [N-1:0] m_map;
  logic         m_sts, m_mode;
  logic [3:0]   m_zm;
  logic [7:0]   m_rd;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int a);
    return m_mode ? 8'h00 : m_map[a*8 +: 8];
  endfunction

  function automatic logic exp_sci();
    return m_sts & gpe_en[2];
  endfunction

  task automatic idle();
    io_sel = 0; io_wr = 0; io_addr = '0; io_wdata = '0;
    hp_add_vld = 0; hp_add_id = '0; gpe_clr_vld = 0; gpe_clr_bits = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_map = N'(1); m_sts = 0; m_mode = 0; m_zm = '0; m_rd = '0;
  endtask

  task automatic rd(int a, string req);
    io_sel = 1; io_wr = 0; io_addr = AW'(a);
    step();
    m_rd = exp_byte(a);
    chk(req, io_rdata, m_rd);
  endtask

  task automatic wr(int a, logic [7:0] d, string req);
    io_sel = 1; io_wr = 1; io_addr = AW'(a); io_wdata = d;
    step();
    if (!m_mode && a < 4) begin
      if (d == 8'h00) m_zm = m_zm | (4'b1 << a);
      else            m_zm = '0;
      if (m_zm == 4'hF) begin m_mode = 1; m_zm = '0; end
    end
    chk({req, " mode"}, modern_mode, m_mode);
    chk({req, " rdata hold R5"}, io_rdata, m_rd);
  endtask

  task automatic hot_clr(bit add, int id, bit clr, logic [7:0] bits);
    hp_add_vld = add; hp_add_id = IW'(id);
    gpe_clr_vld = clr; gpe_clr_bits = bits;
    step();
    if (clr && bits[2]) m_sts = 0;
    if (add) begin m_map[id] = 1'b1; m_sts = 1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    gpe_en = 8'h00;
    do_reset();
    // R11 reset state
    chk("R11 rdata", io_rdata, 8'h00);
    chk("R11 sci", sci, 1'b0);
    chk("R11 mode", modern_mode, 1'b0);
    rd(31, "R11 top byte clear");
    rd(0, "R4 boot bit");
    // R1 R2 mapping and hot-add
    hot_clr(1, 9, 0, 8'h00);
    rd(1, "R1 R2 id 9 -> byte1 bit1");
    chk("R1 value", io_rdata, 8'h02);
    hot_clr(1, 255, 0, 8'h00);
    rd(31, "R1 id 255 -> byte31 bit7");
    // R6 SCI follows enable
    chk("R6 masked sci", sci, 1'b0);
    gpe_en = 8'h04; #1;
    chk("R6 enabled sci", sci, exp_sci());
    gpe_en = 8'hFB; #1;
    chk("R6 other enables", sci, 1'b0);
    gpe_en = 8'h04;
    // R3 writes do not change bits
    wr(1, 8'hFF, "R3 write byte1");
    rd(1, "R3 byte1 unchanged");
    wr(0, 8'h00, "R3 zero write byte0");
    rd(0, "R3 R4 byte0 unchanged");
    // R7 clear behaviour
    hot_clr(0, 0, 1, 8'hFB);
    chk("R7 other clear bits", sci, exp_sci());
    hot_clr(0, 0, 1, 8'h04);
    chk("R7 clear", sci, 1'b0);
    hot_clr(1, 200, 1, 8'hFF);
    chk("R7 set wins", sci, 1'b1);
    hot_clr(0, 0, 1, 8'h04);
    chk("R7 clear again", sci, 1'b0);
    // R9 nonzero write discards progress
    wr(1, 8'h00, "R9 z1");
    wr(2, 8'h00, "R9 z2");
    wr(3, 8'h5A, "R9 nonzero");
    wr(3, 8'h00, "R9 z3 after discard");
    chk("R9 still legacy", modern_mode, 1'b0);
    // R8 offsets past the word do not count; any order
    wr(4, 8'h00, "R8 offset4 ignored");
    wr(1, 8'h00, "R8 z1");
    wr(2, 8'h00, "R8 z2");
    chk("R8 before last", modern_mode, 1'b0);
    wr(0, 8'h00, "R8 last zero");
    chk("R8 switched", modern_mode, 1'b1);
    // R10 sticky, zero reads, hot-add still works
    rd(0, "R10 read zero byte0");
    rd(1, "R10 read zero byte1");
    wr(0, 8'h77, "R10 sticky");
    hot_clr(1, 40, 0, 8'h00);
    chk("R10 event in modern", sci, 1'b1);
    do_reset();
    chk("R11 mode after reset", modern_mode, 1'b0);
    rd(1, "R11 bits cleared");
    chk("R11 sci after reset", sci, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 6);
      case (op)
        0: hot_clr(1, int'($urandom % N), 0, 8'h00);
        1: rd(int'($urandom % 32), "R1 R2 random read");
        2: wr(int'($urandom % 32), 8'($urandom | 1), "R3 random write");
        3: hot_clr(($urandom % 2) == 1, int'($urandom % N), 1, 8'($urandom));
        4: begin gpe_en = 8'($urandom); #1; end
        default: rd(int'($urandom % 4), "R4 random low read");
      endcase
      chk("R6 random sci", sci, exp_sci());
    end
    for (int a = 0; a < 32; a++) rd(a, "R1 sweep");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule